// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small memory-mapped register window between a host bus and an embedded system-controller processor. The host writes optional payload words into a 16-byte outbound buffer, sets the source or destination pointers if the command needs them, and then writes a packed command word. That single write latches the command, marks the mailbox busy and sends a one-cycle interrupt pulse to the controller.

The controller has its own port. It sees the latched command and pointers, reads the outbound buffer by word index, fills a 16-byte inbound buffer, and ends the transaction with a done strobe that carries an error flag, an 8-bit error code and an initiator id. The host polls the packed status word. If the command asked for it, the host also gets a single-cycle completion pulse that needs no clearing.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset, busy is 0, a host read of the status word at offset 0x04 returns 0, and both interrupt outputs are low.
- R2: A host write to offset 0x00 while idle is accepted. It latches the word on `c_cmd`, raises `c_irq` for exactly one cycle, and sets busy. Busy shows in status bit 0, and status bits 7:4 copy command bits 15:12.
- R3: A host write to offset 0x00 while busy is ignored. `c_cmd` stays unchanged and no `c_irq` pulse occurs.
- R4: A `c_done` strobe while busy clears busy and loads three status fields: the error flag into bit 1, `c_init_id` into bits 15:8, and `c_err_code` into bits 23:16. A `c_done` while idle changes nothing.
- R5: `h_irq` pulses for exactly one cycle on completion when bit 8 of the latched command (the completion-interrupt request) is 1, and stays low otherwise.
- R6: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C fill outbound words 0 to 3. The controller reads word `c_wb_idx` on `c_wb_data` one cycle after presenting the index.
- R7: The controller writes inbound word `c_rb_idx` with `c_rb_we`. The host reads inbound words 0 to 3 at offsets 0x90, 0x94, 0x98 and 0x9C.
- R8: Host writes to offset 0x08 appear on `c_src_ptr`, and writes to offset 0x0C appear on `c_dst_ptr`, from the next cycle on.
- R9: Host reads of the write-only locations (command, pointers, outbound buffer) and of unmapped offsets return 0.
- R10: Host read data is valid in the cycle right after the cycle in which `h_rd` is sampled.
- R11: Accepting a command clears the status error flag and error code. The initiator id keeps its last completed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after h_rd |
| h_irq | output | 1 | Completion pulse to host |
| c_irq | output | 1 | New-command pulse to controller |
| c_cmd | output | 32 | Latched command word |
| c_src_ptr | output | 32 | Source pointer |
| c_dst_ptr | output | 32 | Destination pointer |
| c_wb_idx | input | 2 | Outbound buffer word index |
| c_wb_data | output | 32 | Outbound buffer word, registered |
| c_rb_we | input | 1 | Inbound buffer write enable |
| c_rb_idx | input | 2 | Inbound buffer word index |
| c_rb_data | input | 32 | Inbound buffer write data |
| c_done | input | 1 | Completion strobe |
| c_err | input | 1 | Error flag reported with c_done |
| c_err_code | input | 8 | Error code reported with c_done |
| c_init_id | input | 8 | Initiator id reported with c_done |

## Verification
The command and completion path is driven from a table of five command words. The table covers every combination of the completion-interrupt bit and the error flag, the command id values 0x0 and 0xF (the ends of the field), and all-ones error codes and initiator ids. Together these entries separate packing mistakes in the status fields and a wrong completion-interrupt bit from correct behaviour. Directed sequences then cover the cases where a stimulus must have no effect: a second command while busy and a done strobe while idle. The pointers and both buffers are checked with a distinct pattern per word, so that index swaps show up. Reads of write-only and unmapped offsets must come back zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h08;
  localparam logic [7:0] OFS_DST  = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  // command word, LSB first: opcode, ioc, reserved, id, size, reserved
  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] cmd_id;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] opcode;
  } cmd_t;

  // status word, LSB first: busy, error, reserved, id, initiator, code, reserved
  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] err_code;
    logic [7:0] init_id;
    logic [3:0] cmd_id;
    logic [1:0] rsv_lo;
    logic       err;
    logic       busy;
  } stat_t;
endpackage

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic       done,
  input  logic       done_err,
  input  logic [7:0] done_code,
  input  logic [7:0] done_init,
  output cmd_t       cmd_q,
  output stat_t      stat,
  output logic       ctl_irq,
  output logic       host_irq
);
  logic       busy_q;
  logic       err_q;
  logic [7:0] code_q;
  logic [7:0] init_q;
  logic       accept;
  logic       finish;

  assign accept = cmd_we && !busy_q;
  assign finish = done && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= '0;
      init_q   <= '0;
      ctl_irq  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      ctl_irq  <= accept;
      host_irq <= finish && cmd_q.ioc;
      if (accept) begin
        cmd_q  <= cmd_t'(cmd_wdata);
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
        init_q <= done_init;
      end
    end
  end

  always_comb begin
    stat          = '0;
    stat.busy     = busy_q;
    stat.err      = err_q;
    stat.cmd_id   = cmd_q.cmd_id;
    stat.init_id  = init_q;
    stat.err_code = code_q;
  end

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    cmd_we && !busy_q |=> busy_q && ctl_irq); // R2
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_we && busy_q && !done |=> $stable(cmd_q) && !ctl_irq); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done && busy_q |=> !busy_q); // R4
  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (rst)
    done && !busy_q && !cmd_we |=> $stable(stat)); // R4
  AST_HIRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> $fell(busy_q)); // R5
  AST_CIRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ctl_irq |=> !ctl_irq); // R2
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 16,
  localparam int WORDS    = BUF_BYTES / 4,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              c_irq,
  output logic [31:0]       c_cmd,
  output logic [31:0]       c_src_ptr,
  output logic [31:0]       c_dst_ptr,
  input  logic [IDX_W-1:0]  c_wb_idx,
  output logic [31:0]       c_wb_data,
  input  logic              c_rb_we,
  input  logic [IDX_W-1:0]  c_rb_idx,
  input  logic [31:0]       c_rb_data,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [7:0]        c_err_code,
  input  logic [7:0]        c_init_id
);
  localparam int WIN_LO = IDX_W + 2;

  logic              hit_cmd, hit_stat, hit_src, hit_dst, hit_wb, hit_rb;
  logic [IDX_W-1:0]  h_idx;
  cmd_t              cmd_q;
  stat_t             stat;
  logic [31:0]       src_q, dst_q;
  logic [31:0]       reg_rd_q;
  logic              rb_sel_q;
  logic [31:0]       rb_dout;

  assign hit_cmd  = h_addr == ADDR_W'(OFS_CMD);
  assign hit_stat = h_addr == ADDR_W'(OFS_STAT);
  assign hit_src  = h_addr == ADDR_W'(OFS_SRC);
  assign hit_dst  = h_addr == ADDR_W'(OFS_DST);
  assign hit_wb   = h_addr[ADDR_W-1:WIN_LO] == OFS_WBUF[ADDR_W-1:WIN_LO];
  assign hit_rb   = h_addr[ADDR_W-1:WIN_LO] == OFS_RBUF[ADDR_W-1:WIN_LO];
  assign h_idx    = h_addr[WIN_LO-1:2];

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (h_wr && hit_cmd),
    .cmd_wdata (h_wdata),
    .done      (c_done),
    .done_err  (c_err),
    .done_code (c_err_code),
    .done_init (c_init_id),
    .cmd_q     (cmd_q),
    .stat      (stat),
    .ctl_irq   (c_irq),
    .host_irq  (h_irq)
  );

  mbx_buf #(.DEPTH(WORDS), .W(32)) u_wbuf (
    .clk   (clk),
    .we    (h_wr && hit_wb),
    .widx  (h_idx),
    .wdata (h_wdata),
    .ridx  (c_wb_idx),
    .rdata (c_wb_data)
  );

  mbx_buf #(.DEPTH(WORDS), .W(32)) u_rbuf (
    .clk   (clk),
    .we    (c_rb_we),
    .widx  (c_rb_idx),
    .wdata (c_rb_data),
    .ridx  (h_idx),
    .rdata (rb_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      dst_q    <= '0;
      reg_rd_q <= '0;
      rb_sel_q <= 1'b0;
    end else begin
      if (h_wr && hit_src) src_q <= h_wdata;
      if (h_wr && hit_dst) dst_q <= h_wdata;
      rb_sel_q <= h_rd && hit_rb;
      reg_rd_q <= (h_rd && hit_stat) ? 32'(stat) : '0;
    end
  end

  assign h_rdata   = rb_sel_q ? rb_dout : reg_rd_q;
  assign c_cmd     = 32'(cmd_q);
  assign c_src_ptr = src_q;
  assign c_dst_ptr = dst_q;

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    h_rd && (hit_cmd || hit_src || hit_dst || hit_wb) |=> h_rdata == '0); // R9
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    h_wr && hit_src |=> c_src_ptr == $past(h_wdata)); // R8
endmodule

// File: tb/test_mbx_host_mailbox.sv
module test_mbx_host_mailbox;
  logic        clk = 1'b0;
  logic        rst;
  logic        h_wr, h_rd;
  logic [7:0]  h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic        h_irq, c_irq;
  logic [31:0] c_cmd, c_src_ptr, c_dst_ptr, c_wb_data, c_rb_data;
  logic [1:0]  c_wb_idx, c_rb_idx;
  logic        c_rb_we, c_done, c_err;
  logic [7:0]  c_err_code, c_init_id;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mbx_host_mailbox i_mbx_host_mailbox (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .c_irq(c_irq),
    .c_cmd(c_cmd), .c_src_ptr(c_src_ptr), .c_dst_ptr(c_dst_ptr),
    .c_wb_idx(c_wb_idx), .c_wb_data(c_wb_data), .c_rb_we(c_rb_we),
    .c_rb_idx(c_rb_idx), .c_rb_data(c_rb_data), .c_done(c_done),
    .c_err(c_err), .c_err_code(c_err_code), .c_init_id(c_init_id)
  );

  // fields: [48:17] command, [16] error, [15:8] code, [7:0] initiator
  localparam logic [48:0] VEC [5] = '{
    {32'h0003_01FF, 1'b0, 8'h00, 8'h11},
    {32'h0004_50F8, 1'b1, 8'h5A, 8'h22},
    {32'h0000_F1EF, 1'b1, 8'hFF, 8'hFF},
    {32'h000C_2000, 1'b0, 8'h00, 8'h00},
    {32'h0010_A1F4, 1'b0, 8'h3C, 8'h81}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d, output logic irq);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
    irq = c_irq;
  endtask

  // data is sampled in the cycle after h_rd (R10)
  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    h_rd = 1'b1; h_addr = a;
    @(negedge clk);
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic ctl_done(input logic e, input logic [7:0] code, input logic [7:0] ini,
                          output logic irq);
    @(negedge clk);
    c_done = 1'b1; c_err = e; c_err_code = code; c_init_id = ini;
    @(negedge clk);
    c_done = 1'b0;
    irq = h_irq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic        irq;
    logic [31:0] rd, cmd, exp_stat;
    logic [7:0]  last_init;
    h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
    c_wb_idx = 0; c_rb_we = 0; c_rb_idx = 0; c_rb_data = 0;
    c_done = 0; c_err = 0; c_err_code = 0; c_init_id = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 h_irq", {31'b0, h_irq}, 32'd0);
    check("R1 c_irq", {31'b0, c_irq}, 32'd0);
    host_read(8'h04, rd);
    check("R1 status", rd, 32'd0);

    // table walk: R2 R4 R5 R11
    last_init = 8'h00;
    for (int i = 0; i < 5; i++) begin
      cmd = VEC[i][48:17];
      host_write(8'h00, cmd, irq);
      check("R2 c_irq pulse", {31'b0, irq}, 32'd1);
      check("R2 c_cmd", c_cmd, cmd);
      @(negedge clk);
      check("R2 c_irq single", {31'b0, c_irq}, 32'd0);
      host_read(8'h04, rd);
      exp_stat = {8'h00, 8'h00, last_init, cmd[15:12], 2'b00, 1'b0, 1'b1};
      check("R2 R11 status busy", rd, exp_stat);
      ctl_done(VEC[i][16], VEC[i][15:8], VEC[i][7:0], irq);
      check("R5 h_irq", {31'b0, irq}, {31'b0, cmd[8]});
      @(negedge clk);
      check("R5 h_irq single", {31'b0, h_irq}, 32'd0);
      host_read(8'h04, rd);
      exp_stat = {8'h00, VEC[i][15:8], VEC[i][7:0], cmd[15:12], 2'b00, VEC[i][16], 1'b0};
      check("R4 status done", rd, exp_stat);
      last_init = VEC[i][7:0];
    end

    // R3 command while busy ignored
    host_write(8'h00, 32'h0001_3055, irq);
    host_write(8'h00, 32'h0002_7166, irq);
    check("R3 no c_irq", {31'b0, irq}, 32'd0);
    check("R3 c_cmd kept", c_cmd, 32'h0001_3055);
    host_read(8'h04, rd);
    check("R3 status id kept", rd, {8'h00, 8'h00, last_init, 4'h3, 2'b00, 1'b0, 1'b1});
    ctl_done(1'b0, 8'h00, 8'h44, irq);
    check("R5 no ioc no h_irq", {31'b0, irq}, 32'd0);

    // R4 done while idle ignored
    ctl_done(1'b1, 8'h99, 8'h77, irq);
    check("R5 idle done no h_irq", {31'b0, irq}, 32'd0);
    host_read(8'h04, rd);
    check("R4 idle done no effect", rd, {8'h00, 8'h00, 8'h44, 4'h3, 2'b00, 1'b0, 1'b0});

    // R8 pointers
    host_write(8'h08, 32'hA5A5_0001, irq);
    host_write(8'h0C, 32'h5A5A_0002, irq);
    check("R8 src ptr", c_src_ptr, 32'hA5A5_0001);
    check("R8 dst ptr", c_dst_ptr, 32'h5A5A_0002);

    // R6 outbound buffer
    for (int w = 0; w < 4; w++) host_write(8'h80 + 8'(4*w), 32'hC0DE_0000 + 32'(w), irq);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      c_wb_idx = 2'(w);
      @(negedge clk);
      check("R6 outbound word", c_wb_data, 32'hC0DE_0000 + 32'(w));
    end

    // R7 inbound buffer
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      c_rb_we = 1'b1; c_rb_idx = 2'(w); c_rb_data = 32'hBEEF_0010 * 32'(w + 1);
    end
    @(negedge clk);
    c_rb_we = 1'b0;
    for (int w = 3; w >= 0; w--) begin
      host_read(8'h90 + 8'(4*w), rd);
      check("R7 R10 inbound word", rd, 32'hBEEF_0010 * 32'(w + 1));
    end

    // R9 write-only and unmapped reads
    host_read(8'h00, rd); check("R9 cmd reads zero", rd, 32'd0);
    host_read(8'h08, rd); check("R9 src reads zero", rd, 32'd0);
    host_read(8'h0C, rd); check("R9 dst reads zero", rd, 32'd0);
    host_read(8'h84, rd); check("R9 outbound reads zero", rd, 32'd0);
    host_read(8'h40, rd); check("R9 unmapped reads zero", rd, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule